// File: doc/BRIEF.md
# Output Fault Response Sequencer

This block is the per-channel decision engine that sits between the output fault comparators of a switching regulator and its gate drivers. It watches three fault flags: output overvoltage, output undervoltage and output overcurrent. It applies a programmable response to each one: ignore it, stop switching and stay off, or stop switching and restart after a programmable wait. Each shutdown response can act at once or only after the fault has stayed present for a deglitch window.

Overvoltage takes a hardware path that no response code can override. The high-side switch is forced off and the low-side switch is forced on as a crowbar. If the reverse-current limit trips while this crowbar is on, both switches open, and they stay open until the overvoltage flag falls. Any fault that is not ignored sets a sticky per-fault status bit, which raises an alert request until software clears it.

Top module: `fault_resp_seq`

## Requirements
- R1: While reset is low, `top_en`, `bot_en`, `running`, `fault_sts` and `alert` are all 0. On the first clock edge after reset is released with `run_en` high, the channel starts running, and `top_en` and `bot_en` both go to 1.
- R2: A response code is 5 bits. Bits [4:3] select the action: 00 ignore, 01 latch off, 10 retry, 11 pull-down only (for undervoltage and overcurrent, 11 behaves as ignore). Bits [2:0] hold the deglitch count N.
- R3: A fault whose action is ignore does not stop the channel and sets no status bit.
- R4: A latch-off or retry action takes effect only once the fault flag has been sampled high on N×DGL_TICKS+1 consecutive edges of a constantly high `tick_us`. With N=0 it takes effect on the first edge. A shorter pulse has no effect.
- R5: A latch-off stops switching (`running`=0, both gate enables 0 unless overvoltage is present). The channel stays off until `clr_i` is pulsed or `run_en` is dropped and raised again.
- R6: A retry stops switching for the retry delay in milliseconds (US_PER_MS ticks each) and then restarts. If the fault is still present, the channel shuts down on the next edge and waits a full delay again.
- R7: A retry delay below MIN_RETRY_MS is treated as MIN_RETRY_MS.
- R8: While `ov_cmp` is high, `top_en` is 0 and `bot_en` is 1 in the same cycle, whatever the state or the response code, unless R9 applies.
- R9: When `rev_lim` is high while `ov_cmp` is high, both gate enables go to 0 in the same cycle. They stay 0 until `ov_cmp` falls, even after `rev_lim` drops.
- R10: An overvoltage whose action is pull-down only (or ignore) never stops switching. When `ov_cmp` falls, both gate enables return to 1.
- R11: `fault_sts` bit 0 (overvoltage), bit 1 (undervoltage) and bit 2 (overcurrent) are set on the edge after their fault is reported. An overvoltage is reported whenever its flag is high; the other two are reported when they trigger a latch-off or retry. The bits hold until `clr_i`, a new report wins over a clear in the same cycle, and `alert` is high while any bit is set.
- R12: When a latch-off and a retry trigger on the same edge, latch-off wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| run_en | input | 1 | Channel enable; a low-high toggle exits latch-off |
| clr_i | input | 1 | Pulse: clears the status bits and exits latch-off |
| ov_cmp | input | 1 | Output overvoltage comparator |
| uv_cmp | input | 1 | Output undervoltage comparator |
| oc_cmp | input | 1 | Output overcurrent flag |
| rev_lim | input | 1 | Reverse-current limit reached |
| ov_code | input | 5 | Overvoltage response code |
| uv_code | input | 5 | Undervoltage response code |
| oc_code | input | 5 | Overcurrent response code |
| retry_ms | input | 17 | Retry delay in milliseconds |
| top_en | output | 1 | High-side switch enable |
| bot_en | output | 1 | Low-side switch enable |
| running | output | 1 | Channel switching |
| fault_sts | output | 3 | Sticky fault bits {oc, uv, ov} |
| alert | output | 1 | Alert request |

## Verification
The bench targets the deglitch boundary, driving pulses one edge shorter than, equal to and one edge longer than the window. An off-by-one counter would trip on the shorter pulse or miss the longer one. It measures the exact retry wait for a value below the floor and one above it, and for a fault that persists through the restart. This catches a missing clamp, a prescaler off by one and a timer that is not reloaded on re-trip. It drives random overvoltage and reverse-limit patterns and checks the gates against a model every cycle, so a reverse cutoff that is not held, or a crowbar that obeys the response code, shows up as a wrong gate level. It also makes latch-off and retry fire together to catch a wrong priority.

// File: rtl/fsr_pkg.sv
// Package: shared types of the output fault response sequencer.
// Assumes a 2-bit action field at bits [4:3] of every response code.
package fsr_pkg;
    localparam int NFAULT = 3;
    localparam int CODE_W = 5;
    localparam int NSEL_W = 3;
    localparam int FI_OV  = 0;
    localparam int FI_UV  = 1;
    localparam int FI_OC  = 2;

    typedef enum logic [1:0] {
        ACT_IGNORE = 2'd0,
        ACT_LATCH  = 2'd1,
        ACT_RETRY  = 2'd2,
        ACT_PULLDN = 2'd3
    } act_e;

    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_RUN     = 2'd1,
        ST_LATCHED = 2'd2,
        ST_RETRY   = 2'd3
    } state_e;
endpackage

// File: rtl/fsr_deglitch.sv
// Deglitch filter for one fault flag.
// Counts microsecond ticks while the flag is high and reports the fault
// once the count reaches n_sel*DGL_TICKS. The count restarts whenever the
// flag is low. With n_sel=0 the flag passes straight through.
module fsr_deglitch #(
    parameter int DGL_TICKS = 10,
    parameter int NW        = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_us,
    input  logic          flag,
    input  logic [NW-1:0] n_sel,
    output logic          qual
);
    localparam int LIM_MAX = DGL_TICKS * ((1 << NW) - 1);
    localparam int CW      = $clog2(LIM_MAX + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    // Window length in ticks for the selected step count.
    assign lim = CW'(n_sel) * CW'(DGL_TICKS);

    // Persistence counter, saturating at the window length.
    always_ff @(posedge clk) begin
        if (!rst_n || !flag) begin
            cnt <= '0;
        end else if (tick_us && (cnt < lim)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign qual = flag && (cnt >= lim);

    // R4: a flag that has just risen cannot qualify when a window is set.
    a_r4_no_early_qual: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flag) && (n_sel != '0)) |-> !qual);
endmodule

// File: rtl/fsr_retry_timer.sv
// Retry delay timer.
// Loads a delay in milliseconds and counts it down using a microsecond tick
// prescaled by US_PER_MS. done is high while the count is zero.
module fsr_retry_timer #(
    parameter int US_PER_MS = 1000,
    parameter int MS_W      = 17
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_us,
    input  logic            load,
    input  logic [MS_W-1:0] load_ms,
    output logic            done
);
    localparam int PRE_W = (US_PER_MS > 1) ? $clog2(US_PER_MS) : 1;
    localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(US_PER_MS - 1);

    logic [PRE_W-1:0] pre_cnt;
    logic [MS_W-1:0]  ms_cnt;

    // Prescaler and millisecond down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cnt <= '0;
            ms_cnt  <= '0;
        end else if (load) begin
            pre_cnt <= '0;
            ms_cnt  <= load_ms;
        end else if (tick_us && (ms_cnt != '0)) begin
            if (pre_cnt == PRE_TOP) begin
                pre_cnt <= '0;
                ms_cnt  <= ms_cnt - 1'b1;
            end else begin
                pre_cnt <= pre_cnt + 1'b1;
            end
        end
    end

    assign done = (ms_cnt == '0);

    // R6: without a load the remaining delay never grows.
    a_r6_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (ms_cnt <= $past(ms_cnt)));
endmodule

// File: rtl/fault_resp_seq.sv
// Output fault response sequencer, one channel.
// Filters the overvoltage, undervoltage and overcurrent flags and applies
// each fault's response code (ignore / latch off / retry / pull-down only).
// Drives the gate enables with an overvoltage crowbar that no code overrides
// and a reverse-current cutoff held for the rest of the overvoltage event.
// Assumes tick_us is a single-cycle pulse and all inputs are synchronous.
module fault_resp_seq
    import fsr_pkg::*;
#(
    parameter int US_PER_MS    = 1000,
    parameter int MIN_RETRY_MS = 120,
    parameter int DGL_TICKS    = 10,
    parameter int RETRY_W      = 17
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_us,
    input  logic               run_en,
    input  logic               clr_i,
    input  logic               ov_cmp,
    input  logic               uv_cmp,
    input  logic               oc_cmp,
    input  logic               rev_lim,
    input  logic [CODE_W-1:0]  ov_code,
    input  logic [CODE_W-1:0]  uv_code,
    input  logic [CODE_W-1:0]  oc_code,
    input  logic [RETRY_W-1:0] retry_ms,
    output logic               top_en,
    output logic               bot_en,
    output logic               running,
    output logic [NFAULT-1:0]  fault_sts,
    output logic               alert
);
    localparam logic [RETRY_W-1:0] MIN_MS = RETRY_W'(MIN_RETRY_MS);

    state_e              state, nxt;
    logic [NFAULT-1:0]   flag_v, qual_v, latch_v, retry_v, report_v;
    logic [CODE_W-1:0]   code_v [NFAULT];
    logic [RETRY_W-1:0]  retry_eff;
    logic                tmr_load, tmr_done;
    logic                rev_cut_q, cut_now;

    assign flag_v        = {oc_cmp, uv_cmp, ov_cmp};
    assign code_v[FI_OV] = ov_code;
    assign code_v[FI_UV] = uv_code;
    assign code_v[FI_OC] = oc_code;

    // Per-fault filter and action decode.
    for (genvar g = 0; g < NFAULT; g++) begin : g_fault
        act_e act;
        assign act = act_e'(code_v[g][CODE_W-1:CODE_W-2]);

        fsr_deglitch #(
            .DGL_TICKS (DGL_TICKS),
            .NW        (NSEL_W)
        ) u_dgl (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_us (tick_us),
            .flag    (flag_v[g]),
            .n_sel   (code_v[g][NSEL_W-1:0]),
            .qual    (qual_v[g])
        );

        assign latch_v[g] = qual_v[g] && (act == ACT_LATCH);
        assign retry_v[g] = qual_v[g] && (act == ACT_RETRY);

        if (g == FI_OV) begin : g_ov_rep
            assign report_v[g] = flag_v[g];
        end else begin : g_other_rep
            assign report_v[g] = latch_v[g] | retry_v[g];
        end
    end

    // Floor on the programmed retry delay.
    assign retry_eff = (retry_ms < MIN_MS) ? MIN_MS : retry_ms;

    fsr_retry_timer #(
        .US_PER_MS (US_PER_MS),
        .MS_W      (RETRY_W)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_us (tick_us),
        .load    (tmr_load),
        .load_ms (retry_eff),
        .done    (tmr_done)
    );

    // Next-state and timer-load decode; latch-off outranks retry.
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        if (!run_en) begin
            nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:     nxt = ST_RUN;
                ST_RUN: begin
                    if (|latch_v) begin
                        nxt = ST_LATCHED;
                    end else if (|retry_v) begin
                        nxt      = ST_RETRY;
                        tmr_load = 1'b1;
                    end
                end
                ST_LATCHED: if (clr_i) nxt = ST_RUN;
                ST_RETRY:   if (tmr_done) nxt = ST_RUN;
                default:    nxt = ST_OFF;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    // Reverse-current cutoff memory, released when overvoltage clears.
    assign cut_now = ov_cmp && (rev_lim || rev_cut_q);
    always_ff @(posedge clk) begin
        if (!rst_n) rev_cut_q <= 1'b0;
        else        rev_cut_q <= cut_now;
    end

    // Sticky status: a new report wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) fault_sts <= '0;
        else        fault_sts <= (clr_i ? '0 : fault_sts) | report_v;
    end

    // Gate outputs with the overvoltage override.
    assign running = (state == ST_RUN);
    assign top_en  = running && !ov_cmp;
    assign bot_en  = ov_cmp ? !cut_now : running;
    assign alert   = |fault_sts;

    // R8: the high side is never enabled during overvoltage.
    a_r8_crowbar_top_off: assert property (@(posedge clk) disable iff (!rst_n)
        ov_cmp |-> !top_en);
    // R9: reverse limit during overvoltage opens both switches.
    a_r9_rev_cut: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_cmp && rev_lim) |-> (!top_en && !bot_en));
    // R5: latch-off holds without a clear or an enable drop.
    a_r5_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LATCHED && run_en && !clr_i) |=> (state == ST_LATCHED));
    // R12: latch request while running always ends in latch-off.
    a_r12_latch_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && run_en && (|latch_v)) |=> (state == ST_LATCHED));
    // R11: status bits stay set without a clear.
    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((fault_sts & $past(fault_sts)) == $past(fault_sts)));
    // R11: any report raises the alert on the next cycle.
    a_r11_alert_set: assert property (@(posedge clk) disable iff (!rst_n)
        (|report_v) |=> alert);
    // R3: with nothing to act on, a running channel keeps running.
    a_r3_stay_run: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && run_en && !(|latch_v) && !(|retry_v)) |=> running);
endmodule

// File: tb/test_fault_resp_seq.sv
// Self-checking bench for fault_resp_seq: directed corner cases plus
// seeded random deglitch and overvoltage patterns.
module test_fault_resp_seq;
    localparam int UPM  = 4;
    localparam int MINR = 120;
    localparam int DGT  = 10;

    logic        clk = 1'b0, rst_n = 1'b0, tick_us = 1'b1, run_en = 1'b1, clr_i = 1'b0;
    logic        ov_cmp = 1'b0, uv_cmp = 1'b0, oc_cmp = 1'b0, rev_lim = 1'b0;
    logic [4:0]  ov_code = '0, uv_code = '0, oc_code = '0;
    logic [16:0] retry_ms = '0;
    logic        top_en, bot_en, running, alert;
    logic [2:0]  fault_sts;
    int          checks = 0, failures = 0;
    bit          finished = 1'b0;

    always #4ns clk = ~clk;

    fault_resp_seq #(
        .US_PER_MS (UPM), .MIN_RETRY_MS (MINR), .DGL_TICKS (DGT), .RETRY_W (17)
    ) i_fault_resp_seq (
        .clk (clk), .rst_n (rst_n), .tick_us (tick_us), .run_en (run_en), .clr_i (clr_i),
        .ov_cmp (ov_cmp), .uv_cmp (uv_cmp), .oc_cmp (oc_cmp), .rev_lim (rev_lim),
        .ov_code (ov_code), .uv_code (uv_code), .oc_code (oc_code), .retry_ms (retry_ms),
        .top_en (top_en), .bot_en (bot_en), .running (running),
        .fault_sts (fault_sts), .alert (alert)
    );

    function automatic int exp_retry_cycles(int ms);
        return ((ms < MINR) ? MINR : ms) * UPM + 1;
    endfunction

    function automatic bit exp_trip(int n, int len);
        return len >= n * DGT + 1;
    endfunction

    function automatic logic [4:0] mk_code(int act, int n);
        return {act[1:0], n[2:0]};
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_pulse();
        clr_i = 1'b1;
        step(1);
        clr_i = 1'b0;
    endtask

    task automatic wait_run(output int cnt);
        cnt = 0;
        while (!running && cnt < 5000) begin
            cnt++;
            step(1);
        end
    endtask

    initial begin
        #(8ns * 190000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL R1 watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int cnt;
        bit cut_q;
        void'($urandom(32'd20240611));

        // R1: reset state and start-up
        step(3);
        chk("R1 running in reset", running, 0);
        chk("R1 gates in reset", {top_en, bot_en}, 0);
        chk("R1 status in reset", {fault_sts, alert}, 0);
        rst_n = 1'b1;
        step(1);
        chk("R1 running after reset", running, 1);
        chk("R1 gates after reset", {top_en, bot_en}, 3);

        // R3/R2: ignore codes for undervoltage (00) and overcurrent (11)
        uv_code = mk_code(0, 0); oc_code = mk_code(3, 0);
        uv_cmp = 1'b1; oc_cmp = 1'b1;
        step(20);
        chk("R3 ignored faults keep running", running, 1);
        chk("R3 ignored faults set no status", fault_sts, 0);
        uv_cmp = 1'b0; oc_cmp = 1'b0;
        step(2);

        // R8/R10/R11: overvoltage pull-down only
        ov_code = mk_code(3, 0);
        ov_cmp = 1'b1;
        #1ns;
        chk("R8 crowbar same cycle", {top_en, bot_en}, 1);
        step(5);
        chk("R10 pull-down only keeps running", running, 1);
        chk("R11 ov status bit", fault_sts, 3'b001);
        chk("R11 alert", alert, 1);
        ov_cmp = 1'b0;
        step(1);
        chk("R10 gates restored", {top_en, bot_en}, 3);
        clear_pulse();
        chk("R11 clear", {fault_sts, alert}, 0);

        // R9: reverse cutoff held until overvoltage clears
        ov_cmp = 1'b1; rev_lim = 1'b1;
        #1ns;
        chk("R9 cut same cycle", {top_en, bot_en}, 0);
        step(1);
        rev_lim = 1'b0;
        #1ns;
        chk("R9 cut held after limit drops", {top_en, bot_en}, 0);
        step(3);
        chk("R9 cut still held", {top_en, bot_en}, 0);
        ov_cmp = 1'b0;
        #1ns;
        chk("R9 released with ov", {top_en, bot_en}, 3);
        step(1);
        ov_cmp = 1'b1;
        #1ns;
        chk("R9 new ov event not cut", {top_en, bot_en}, 1);
        ov_cmp = 1'b0;
        step(1);
        clear_pulse();

        // R5: immediate latch-off and clear
        uv_code = mk_code(1, 0);
        uv_cmp = 1'b1;
        step(1);
        uv_cmp = 1'b0;
        chk("R5 latched off", running, 0);
        chk("R5 gates off", {top_en, bot_en}, 0);
        chk("R11 uv status bit", fault_sts, 3'b010);
        step(10);
        chk("R5 stays latched", running, 0);
        clear_pulse();
        chk("R5 clear restarts", running, 1);
        chk("R11 clear uv", fault_sts, 0);

        // R5: enable toggle exits latch-off
        oc_code = mk_code(1, 0);
        oc_cmp = 1'b1;
        step(1);
        oc_cmp = 1'b0;
        chk("R5 oc latched", running, 0);
        run_en = 1'b0;
        step(1);
        run_en = 1'b1;
        step(1);
        chk("R5 enable toggle restarts", running, 1);
        clear_pulse();
        oc_code = mk_code(0, 0);

        // R8/R5: overvoltage latch-off keeps crowbar while present
        ov_code = mk_code(1, 0);
        ov_cmp = 1'b1;
        step(1);
        chk("R5 ov latched", running, 0);
        chk("R8 crowbar while latched", {top_en, bot_en}, 1);
        ov_cmp = 1'b0;
        #1ns;
        chk("R5 gates off after ov clears", {top_en, bot_en}, 0);
        clear_pulse();
        chk("R5 restart after ov latch", running, 1);
        ov_code = mk_code(3, 0);

        // R6/R7: retry with delay below the floor
        uv_code = mk_code(2, 0); retry_ms = 17'd5;
        uv_cmp = 1'b1;
        step(1);
        uv_cmp = 1'b0;
        wait_run(cnt);
        chk("R7 clamped retry wait", cnt, exp_retry_cycles(5));
        step(3);
        chk("R6 stays running after retry", running, 1);
        clear_pulse();

        // R6: retry above the floor with persistent fault
        retry_ms = 17'd150;
        uv_cmp = 1'b1;
        step(1);
        wait_run(cnt);
        chk("R6 retry wait", cnt, exp_retry_cycles(150));
        step(1);
        chk("R6 re-trip on persistent fault", running, 0);
        uv_cmp = 1'b0;
        wait_run(cnt);
        chk("R6 reloaded wait", cnt, exp_retry_cycles(150));
        step(3);
        chk("R6 running after fault gone", running, 1);
        clear_pulse();

        // R12: latch-off beats retry
        uv_code = mk_code(1, 0); oc_code = mk_code(2, 0); retry_ms = 17'd0;
        uv_cmp = 1'b1; oc_cmp = 1'b1;
        step(1);
        uv_cmp = 1'b0; oc_cmp = 1'b0;
        chk("R11 both status bits", fault_sts, 3'b110);
        step(600);
        chk("R12 latch wins over retry", running, 0);
        clear_pulse();
        chk("R12 clear restarts", running, 1);
        oc_code = mk_code(0, 0);

        // R4: directed deglitch boundary
        uv_code = mk_code(1, 2);
        uv_cmp = 1'b1;
        step(20);
        uv_cmp = 1'b0;
        chk("R4 pulse at window does not trip", running, 1);
        step(2);
        uv_cmp = 1'b1;
        step(21);
        uv_cmp = 1'b0;
        chk("R4 pulse past window trips", running, 0);
        clear_pulse();

        // R4: random deglitch lengths
        for (int it = 0; it < 10; it++) begin
            int n, len;
            n   = 1 + $urandom_range(0, 2);
            len = n * DGT - 2 + $urandom_range(0, 4);
            uv_code = mk_code(1, n);
            uv_cmp = 1'b1;
            step(len);
            uv_cmp = 1'b0;
            chk("R4 random deglitch", running, exp_trip(n, len) ? 0 : 1);
            step(1);
            clear_pulse();
            chk("R4 recovered", running, 1);
        end
        uv_code = mk_code(0, 0);

        // R8/R9/R10: random overvoltage and reverse-limit patterns
        ov_code = mk_code(3, $urandom_range(0, 7));
        cut_q = 1'b0;
        for (int cyc = 0; cyc < 300; cyc++) begin
            bit ecut;
            if ($urandom_range(0, 2) == 0) ov_cmp = ~ov_cmp;
            rev_lim = ($urandom_range(0, 7) == 0);
            #1ns;
            ecut = ov_cmp && (rev_lim || cut_q);
            chk("R9 random gates", {top_en, bot_en},
                {!ov_cmp, ov_cmp ? !ecut : 1'b1});
            cut_q = ecut;
            step(1);
        end
        ov_cmp = 1'b0; rev_lim = 1'b0;
        step(1);
        chk("R10 still running after random ov", running, 1);
        clear_pulse();
        chk("R11 cleared at end", alert, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule